// File: doc/BRIEF.md
# Multiplexed Bidirectional Port Controller

This block holds the output latches for two eight-bit microcontroller ports and turns them into per-pin drive-enable and drive-value signals. The low port (latch at register address 80h) is open drain in plain I/O use. The high port (latch at A0h) pulls down only, with the pull-up kept outside the block. Software reaches either latch over the internal register bus. A byte write replaces the whole latch. A bit write changes one bit, chosen by a three-bit index. Reads go down two paths: one returns the stored latch, and the other returns the pin level after a two-flop synchroniser.

When an external memory access runs, the block takes over both ports. Each access has an address phase and then a data phase. During the address phase the low port drives address bits 7..0 on every pin and the high port drives bits 15..8. In the data phase of a write, the low port actively drives the write byte. In the data phase of a read, the low port releases its pins, its latch is forced to all ones, and the pin byte is captured into a read-data register when the phase ends. If the external-access strap is low while reset is applied, the high port carries the high address byte from then on.

Top module: `mbport_ctrl`

## Requirements
- R1: While reset is held, both latches become FFh, the bus sequencer goes idle, and the high-address register clears to 00h. After reset with the strap high, neither port drives any pin.
- R2: A byte write (sfr_wr_byte=1) to 80h or A0h replaces that latch at the next clock edge. A write to any other address changes neither latch.
- R3: A bit write (sfr_wr_bit=1) to 80h or A0h sets latch bit sfr_bit_idx to sfr_bit_val and leaves the other seven bits as they were. If a byte write happens in the same cycle, the byte write wins.
- R4: rd_latch returns the latch addressed by sfr_addr (80h or A0h) combinationally. It returns 00h for any other address.
- R5: rd_pin returns the addressed port's pin byte as it stood two clock edges earlier, because of a two-flop synchroniser. It returns 00h for any other address.
- R6: With no access running, low-port pin i has drive enable equal to NOT latch bit i and drive value 0, which makes it open drain.
- R7: With no access running and the strap high at reset, the high port behaves the same way: enable equal to NOT latch, value 0.
- R8: In the cycle after bus_start is accepted (the address phase), p0 drives bus_addr[7:0] and p2 drives bus_addr[15:8], with all enables set to 1. bus_busy is 1 during both phases.
- R9: In the data phase of a write (bus_wr=1), p0 drives the write byte with all enables set and p2 keeps driving the high address.
- R10: In the data phase of a read, p0 enables are all 0. At the edge that ends the phase, bus_rdata takes p0_pin_in and the low-port latch is forced to FFh. The force wins over a register write made in the same cycle.
- R11: If ea_n is low while reset is held, p2 drives the high-address register on every pin from then on, and latch writes no longer reach the p2 pins (they are still stored and can be read back).
- R12: bus_start is ignored while an access is running. The captured address, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ea_n | input | 1 | External-access strap, sampled while reset is held |
| sfr_addr | input | 8 | Register address for writes and reads |
| sfr_wr_byte | input | 1 | Byte write strobe |
| sfr_wr_bit | input | 1 | Bit write strobe |
| sfr_bit_idx | input | 3 | Bit index for bit writes |
| sfr_bit_val | input | 1 | Value for bit writes |
| sfr_wdata | input | 8 | Byte write data |
| rd_latch | output | 8 | Latch read path |
| rd_pin | output | 8 | Synchronised pin read path |
| bus_start | input | 1 | Start an external access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 16 | External access address |
| bus_wdata | input | 8 | External write data |
| bus_rdata | output | 8 | Byte captured at the end of a read data phase |
| bus_busy | output | 1 | An access is in its address or data phase |
| p0_pin_in | input | 8 | Low-port pin levels |
| p0_drv_en | output | 8 | Low-port drive enables |
| p0_drv_val | output | 8 | Low-port drive values |
| p2_pin_in | input | 8 | High-port pin levels |
| p2_drv_en | output | 8 | High-port drive enables |
| p2_drv_val | output | 8 | High-port drive values |

## Verification
The bench walks a vector table of byte and bit writes, including writes to an unrelated address. A decoder that compared too few address bits, or a bit write that disturbed its neighbours, would leave a wrong latch value and wrong enables. The pin-read check samples one edge too early and then on time, so a path that is missing a synchroniser flop, or has one too many, shows up. A read access is issued while bus_start is held through the address phase and an SFR write collides with its data phase. A design that restarted the access would drive the wrong high address, and one that let the write win would leave the low latch short of FFh. A second reset with the strap low must keep p2 on the address even after a latch write.

// File: rtl/mbport_pkg.sv
package mbport_pkg;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int IW = $clog2(DW);
    localparam logic [7:0] LO_PORT_ADDR = 8'h80;
    localparam logic [7:0] HI_PORT_ADDR = 8'hA0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_e;

    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] val;
    } pad_drive_t;

    function automatic pad_drive_t pull_down_only(input logic [DW-1:0] latch);
        pad_drive_t d;
        d.en  = ~latch;
        d.val = '0;
        return d;
    endfunction

    function automatic pad_drive_t push_pull(input logic [DW-1:0] value);
        pad_drive_t d;
        d.en  = '1;
        d.val = value;
        return d;
    endfunction
endpackage

// File: rtl/mbport_latch.sv
module mbport_latch
    import mbport_pkg::*;
#(
    parameter logic [7:0] SFR_ADDR = LO_PORT_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    sfr_addr,
    input  logic          wr_byte,
    input  logic          wr_bit,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    input  logic [DW-1:0] wdata,
    input  logic          force_ones,
    output logic [DW-1:0] q
);
    logic hit;
    assign hit = (sfr_addr == SFR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (force_ones) begin
            q <= '1;
        end else if (hit && wr_byte) begin
            q <= wdata;
        end else if (hit && wr_bit) begin
            q[bit_idx] <= bit_val;
        end
    end

    assert_byte_write_R2: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_byte && !force_ones) |=> (q == $past(wdata)));

    assert_bit_neighbours_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_bit && !wr_byte && !force_ones) |=>
            ((((q ^ $past(q)) & ~(DW'(1) << $past(bit_idx))) == '0) &&
             (q[$past(bit_idx)] == $past(bit_val))));
endmodule

// File: rtl/mbport_sync.sv
module mbport_sync
    import mbport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    logic [DW-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else if (s == 0) begin
                stg[s] <= d;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbport_buscyc.sv
module mbport_buscyc
    import mbport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] p0_pin,
    output bus_phase_e    phase,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          wr_q,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    addr_q  <= addr;
                    wdata_q <= wdata;
                    wr_q    <= wr;
                    phase   <= PH_ADDR;
                end
                PH_ADDR: phase <= PH_DATA;
                PH_DATA: begin
                    if (!wr_q) rdata <= p0_pin;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> ((addr_q == $past(addr_q)) && (wr_q == $past(wr_q))));

    assert_read_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !wr_q) |=> (rdata == $past(p0_pin)));
endmodule

// File: rtl/mbport_ctrl.sv
module mbport_ctrl
    import mbport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ea_n,
    input  logic [7:0]    sfr_addr,
    input  logic          sfr_wr_byte,
    input  logic          sfr_wr_bit,
    input  logic [2:0]    sfr_bit_idx,
    input  logic          sfr_bit_val,
    input  logic [7:0]    sfr_wdata,
    output logic [7:0]    rd_latch,
    output logic [7:0]    rd_pin,
    input  logic          bus_start,
    input  logic          bus_wr,
    input  logic [15:0]   bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          bus_busy,
    input  logic [7:0]    p0_pin_in,
    output logic [7:0]    p0_drv_en,
    output logic [7:0]    p0_drv_val,
    input  logic [7:0]    p2_pin_in,
    output logic [7:0]    p2_drv_en,
    output logic [7:0]    p2_drv_val
);
    bus_phase_e    phase;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;
    logic [DW-1:0] lo_latch, hi_latch, lo_sync, hi_sync;
    logic          ext_strap;
    logic          lo_force;
    pad_drive_t    lo_drv, hi_drv;

    always_ff @(posedge clk) begin
        if (rst) ext_strap <= ~ea_n;
    end

    assign lo_force = (phase == PH_DATA) && !wr_q;

    mbport_buscyc u_bus (
        .clk(clk), .rst(rst), .start(bus_start), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .p0_pin(p0_pin_in), .phase(phase), .addr_q(addr_q),
        .wdata_q(wdata_q), .wr_q(wr_q), .rdata(bus_rdata)
    );

    mbport_latch #(.SFR_ADDR(LO_PORT_ADDR)) u_lo_latch (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .wr_byte(sfr_wr_byte),
        .wr_bit(sfr_wr_bit), .bit_idx(sfr_bit_idx), .bit_val(sfr_bit_val),
        .wdata(sfr_wdata), .force_ones(lo_force), .q(lo_latch)
    );

    mbport_latch #(.SFR_ADDR(HI_PORT_ADDR)) u_hi_latch (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .wr_byte(sfr_wr_byte),
        .wr_bit(sfr_wr_bit), .bit_idx(sfr_bit_idx), .bit_val(sfr_bit_val),
        .wdata(sfr_wdata), .force_ones(1'b0), .q(hi_latch)
    );

    mbport_sync #(.STAGES(2)) u_lo_sync (.clk(clk), .rst(rst), .d(p0_pin_in), .q(lo_sync));
    mbport_sync #(.STAGES(2)) u_hi_sync (.clk(clk), .rst(rst), .d(p2_pin_in), .q(hi_sync));

    always_comb begin
        unique case (phase)
            PH_ADDR: lo_drv = push_pull(addr_q[DW-1:0]);
            PH_DATA: lo_drv = wr_q ? push_pull(wdata_q) : '{en: '0, val: '0};
            default: lo_drv = pull_down_only(lo_latch);
        endcase
        if (phase != PH_IDLE || ext_strap) hi_drv = push_pull(addr_q[AW-1:DW]);
        else                               hi_drv = pull_down_only(hi_latch);
    end

    always_comb begin
        rd_latch = '0;
        rd_pin   = '0;
        if (sfr_addr == LO_PORT_ADDR) begin
            rd_latch = lo_latch;
            rd_pin   = lo_sync;
        end else if (sfr_addr == HI_PORT_ADDR) begin
            rd_latch = hi_latch;
            rd_pin   = hi_sync;
        end
    end

    assign p0_drv_en  = lo_drv.en;
    assign p0_drv_val = lo_drv.val;
    assign p2_drv_en  = hi_drv.en;
    assign p2_drv_val = hi_drv.val;
    assign bus_busy   = (phase != PH_IDLE);

    assert_reset_released_R1: assert property (@(posedge clk)
        rst |=> (p0_drv_en == '0 && lo_latch == '1 && hi_latch == '1 && !bus_busy));

    assert_addr_phase_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(bus_start) && !$past(bus_busy)) |->
            (p0_drv_en == '1 && p0_drv_val == $past(bus_addr[7:0]) &&
             p2_drv_val == $past(bus_addr[15:8]) && bus_busy));

    assert_read_release_R10: assert property (@(posedge clk) disable iff (rst)
        lo_force |=> (lo_latch == '1));

    assert_strap_drive_R11: assert property (@(posedge clk) disable iff (rst)
        ext_strap |-> (p2_drv_en == '1));
endmodule

// File: tb/mbport_ctrl_tb.sv
`timescale 1ns/1ps
module mbport_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst, ea_n;
    logic [7:0]  sfr_addr, sfr_wdata;
    logic        sfr_wr_byte, sfr_wr_bit, sfr_bit_val;
    logic [2:0]  sfr_bit_idx;
    logic [7:0]  rd_latch, rd_pin;
    logic        bus_start, bus_wr, bus_busy;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [7:0]  p0_pin_in, p0_drv_en, p0_drv_val;
    logic [7:0]  p2_pin_in, p2_drv_en, p2_drv_val;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mbport_ctrl dut_i (.*);

    typedef struct packed {
        logic [7:0] addr;
        logic       is_bit;
        logic [2:0] idx;
        logic       bval;
        logic [7:0] data;
        logic [7:0] exp_lo;
        logic [7:0] exp_hi;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h80, 1'b0, 3'd0, 1'b0, 8'h5A, 8'h5A, 8'hFF},
        '{8'hA0, 1'b0, 3'd0, 1'b0, 8'h3C, 8'h5A, 8'h3C},
        '{8'h80, 1'b1, 3'd0, 1'b1, 8'h00, 8'h5B, 8'h3C},
        '{8'hA0, 1'b1, 3'd7, 1'b1, 8'h00, 8'h5B, 8'hBC},
        '{8'h80, 1'b1, 3'd6, 1'b0, 8'h00, 8'h1B, 8'hBC},
        '{8'h90, 1'b0, 3'd0, 1'b0, 8'h00, 8'h1B, 8'hBC},
        '{8'h90, 1'b1, 3'd1, 1'b0, 8'h00, 8'h1B, 8'hBC},
        '{8'hA0, 1'b1, 3'd2, 1'b0, 8'h00, 8'h1B, 8'hB8}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic do_reset(input logic strap_n);
        @(negedge clk);
        rst = 1'b1; ea_n = strap_n;
        repeat (2) @(negedge clk);
        rst = 1'b0; ea_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        sfr_addr = 8'h00; sfr_wdata = 8'h00; sfr_wr_byte = 0; sfr_wr_bit = 0;
        sfr_bit_idx = 3'd0; sfr_bit_val = 0; bus_start = 0; bus_wr = 0;
        bus_addr = 16'h0; bus_wdata = 8'h0; p0_pin_in = 8'h00; p2_pin_in = 8'h00;
        rst = 1'b1; ea_n = 1'b1;
        do_reset(1'b1);
        @(negedge clk);

        // R1 reset state
        sfr_addr = 8'h80; #1 chk("R1 lo latch", {8'h0, rd_latch}, 16'h00FF);
        sfr_addr = 8'hA0; #1 chk("R1 hi latch", {8'h0, rd_latch}, 16'h00FF);
        chk("R1 p0 en", {8'h0, p0_drv_en}, 16'h0000);
        chk("R1 p2 en", {8'h0, p2_drv_en}, 16'h0000);
        chk("R1 busy", {15'h0, bus_busy}, 16'h0000);

        // R2 R3 R6 R7 vector walk
        foreach (VECS[k]) begin
            @(negedge clk);
            sfr_addr = VECS[k].addr; sfr_wdata = VECS[k].data;
            sfr_bit_idx = VECS[k].idx; sfr_bit_val = VECS[k].bval;
            sfr_wr_byte = !VECS[k].is_bit; sfr_wr_bit = VECS[k].is_bit;
            @(negedge clk);
            sfr_wr_byte = 0; sfr_wr_bit = 0;
            sfr_addr = 8'h80; #1 chk("R2/R3 lo latch", {8'h0, rd_latch}, {8'h0, VECS[k].exp_lo});
            sfr_addr = 8'hA0; #1 chk("R2/R3 hi latch", {8'h0, rd_latch}, {8'h0, VECS[k].exp_hi});
            chk("R6 p0 drive", {p0_drv_en, p0_drv_val}, {~VECS[k].exp_lo, 8'h00});
            chk("R7 p2 drive", {p2_drv_en, p2_drv_val}, {~VECS[k].exp_hi, 8'h00});
        end

        // R3 byte write wins over bit write in same cycle
        @(negedge clk);
        sfr_addr = 8'h80; sfr_wdata = 8'h1B; sfr_wr_byte = 1; sfr_wr_bit = 1;
        sfr_bit_idx = 3'd0; sfr_bit_val = 0;
        @(negedge clk);
        sfr_wr_byte = 0; sfr_wr_bit = 0;
        #1 chk("R3 byte beats bit", {8'h0, rd_latch}, 16'h001B);

        // R4 unrelated address reads zero
        sfr_addr = 8'h90; #1 chk("R4 other addr", {rd_latch, rd_pin}, 16'h0000);

        // R5 synchroniser latency
        p0_pin_in = 8'hA5; p2_pin_in = 8'h3C; sfr_addr = 8'h80;
        @(negedge clk); #1 chk("R5 one edge", {8'h0, rd_pin}, 16'h0000);
        @(negedge clk); #1 chk("R5 two edges", {8'h0, rd_pin}, 16'h00A5);
        sfr_addr = 8'hA0; #1 chk("R5 hi pins", {8'h0, rd_pin}, 16'h003C);

        // R8 R9 write access
        bus_start = 1; bus_wr = 1; bus_addr = 16'h1234; bus_wdata = 8'hC3;
        @(negedge clk);
        bus_start = 0;
        chk("R8 p0 addr", {p0_drv_en, p0_drv_val}, 16'hFF34);
        chk("R8 p2 addr", {p2_drv_en, p2_drv_val}, 16'hFF12);
        chk("R8 busy", {15'h0, bus_busy}, 16'h0001);
        @(negedge clk);
        chk("R9 p0 data", {p0_drv_en, p0_drv_val}, 16'hFFC3);
        chk("R9 p2 addr", {p2_drv_en, p2_drv_val}, 16'hFF12);
        @(negedge clk);
        chk("R6 p0 after write", {p0_drv_en, p0_drv_val}, 16'hE400);
        chk("R7 p2 after write", {p2_drv_en, p2_drv_val}, 16'h4700);

        // R10 R12 read access, start held, colliding register write
        bus_start = 1; bus_wr = 0; bus_addr = 16'hABCD; p0_pin_in = 8'h96;
        @(negedge clk);
        bus_addr = 16'h0000; bus_wr = 1;
        chk("R8 read addr", {p0_drv_en, p0_drv_val}, 16'hFFCD);
        @(negedge clk);
        bus_start = 0;
        sfr_addr = 8'h80; sfr_wdata = 8'h00; sfr_wr_byte = 1;
        chk("R10 p0 released", {8'h0, p0_drv_en}, 16'h0000);
        chk("R12 addr kept", {p2_drv_en, p2_drv_val}, 16'hFFAB);
        @(negedge clk);
        sfr_wr_byte = 0;
        chk("R10 rdata", {8'h0, bus_rdata}, 16'h0096);
        #1 chk("R10 latch forced", {8'h0, rd_latch}, 16'h00FF);
        chk("R12 idle after two phases", {15'h0, bus_busy}, 16'h0000);

        // R11 strap low at reset
        do_reset(1'b0);
        @(negedge clk);
        chk("R11 p2 driven", {p2_drv_en, p2_drv_val}, 16'hFF00);
        sfr_addr = 8'hA0; sfr_wdata = 8'h00; sfr_wr_byte = 1;
        @(negedge clk);
        sfr_wr_byte = 0;
        #1 chk("R11 latch stored", {8'h0, rd_latch}, 16'h0000);
        chk("R11 p2 ignores latch", {p2_drv_en, p2_drv_val}, 16'hFF00);
        bus_start = 1; bus_wr = 1; bus_addr = 16'h7700;
        @(negedge clk);
        bus_start = 0;
        repeat (2) @(negedge clk);
        chk("R11 p2 holds high addr", {p2_drv_en, p2_drv_val}, 16'hFF77);

        summary();
    end
endmodule